// File: doc/BRIEF.md
# SPI Flash Single-Byte PIO Engine

This block gives software byte-at-a-time access to a serial NOR flash through a small byte-wide register port. Software loads a 32-bit byte address into four address registers and picks a lane mode. It then writes a command value into the command register. A read command runs one complete chip-select frame: opcode, address, dummy clocks, one data byte. The byte lands in a read-data register. A write command runs a write-enable frame and then a page-program frame that carries the byte held in the write-data register.

After every completed command the address register increments by one. Software can therefore stream through flash with repeated commands and no address reloads. The lane-mode register chooses the number of lanes for the address phase and the data phase independently, and it also chooses 3-byte or 4-byte addressing. The serial side drives SCK at half the system clock. It has four data lanes, each with its own output enable.

Top module: `spi_pio_byte_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0 and spi_io_oe is 0. The command, read-data and address registers all read 0.
- R2: The register at offset 0x8 holds address bits 7:0, 0x9 holds bits 15:8 and 0xA holds bits 23:16. The most significant address byte sits apart from the others, at offset 0xD. All four read back what was written.
- R3: Writing 0x81 to the command register (offset 0x0) starts one read frame. The command register reads 0x81 while the frame runs and reads 0 once the received byte is in the read-data register (offset 0x1).
- R4: The lane-mode register (offset 0x3) uses these bits: 0 dual read data, 1 dual address, 2 quad read data, 3 quad address, 4 four-byte address. Quad takes priority over dual, and a value of 0 means single lane for both phases. The read opcode comes from offset 0x6 when bit 2 is set, and from offset 0x5 otherwise. The opcode is always sent on IO0.
- R5: The address is sent most significant bit first: 32 bits when mode bit 4 is set, otherwise the low 24 bits. Each SCK carries 1, 2 or 4 address bits according to the address lane count.
- R6: A read inserts dummy clocks after the address. The count is 0 when the data phase is single lane and the fast-read register (offset 0x4, value 0x01) is clear. It is 6 when the address uses four lanes. It is 8 in every other case.
- R7: Read data is sampled on the rising SCK edge. Single lane reads on IO1. Dual places odd bits on IO1 and even bits on IO0, most significant pair first. Quad takes a nibble per clock on IO3..IO0, high nibble first.
- R8: Writing 0x90 to the command register runs an 8-clock frame with opcode 0x06. Chip select then stays high for at least 2 clock cycles. A second frame follows with opcode 0x02, the address on one lane, and the write-data byte (offset 0x2) on IO0.
- R9: Each completed read or write command increments the 32-bit address register by exactly 1, so consecutive commands need no address reload.
- R10: While a command is running, register writes of any kind are ignored. In the idle state, command values other than 0x81 and 0x90 are ignored and start no frame.
- R11: SCK runs at half the clock rate and idles low while chip select is high. Output enables are 0 while chip select is high, during dummy clocks and during read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_io_out | output | 4 | Data lanes driven toward the flash |
| spi_io_oe | output | 4 | Per-lane output enable |
| spi_io_in | input | 4 | Data lanes from the flash |

## Verification
Several properties hold on every cycle and are checked by assertions. SCK stays low and the lanes stay undriven while chip select is high. The output-enable pattern is always one of the three lane shapes. The busy state rises on a start and falls on completion. The address moves only by one at completion, and the read-data byte changes only then. Other behaviour needs a flash model that decodes frames, so only the bench scenarios can show it. This covers opcode choice per mode, the address bits on the wire, the dummy counts, the lane ordering of returned data, the write-enable/program frame pair with its gap, and the fact that writes are dropped while busy.

// File: rtl/spi_pio_pkg.sv
package spi_pio_pkg;

  typedef enum logic [1:0] {SEG_OPC, SEG_ADR, SEG_DMY, SEG_DAT} seg_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} st_e;

  // register offsets
  localparam logic [3:0] RG_CMD   = 4'h0;
  localparam logic [3:0] RG_RDATA = 4'h1;
  localparam logic [3:0] RG_WDATA = 4'h2;
  localparam logic [3:0] RG_MODE  = 4'h3;
  localparam logic [3:0] RG_FAST  = 4'h4;
  localparam logic [3:0] RG_OPA   = 4'h5;
  localparam logic [3:0] RG_OPQ   = 4'h6;
  localparam logic [3:0] RG_A0    = 4'h8;
  localparam logic [3:0] RG_A3    = 4'hD;

  localparam logic [7:0] CMD_RD  = 8'h81;
  localparam logic [7:0] CMD_WR  = 8'h90;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;

  // offset of address byte i; the top byte is placed apart
  function automatic logic [3:0] addr_off(input int i);
    return (i == 3) ? RG_A3 : RG_A0 + 4'(i);
  endfunction

  // lane counts as log2: 0 -> 1 lane, 1 -> 2 lanes, 2 -> 4 lanes
  function automatic logic [1:0] dlg_of(input logic [4:0] m);
    return m[2] ? 2'd2 : (m[0] ? 2'd1 : 2'd0);
  endfunction

  function automatic logic [1:0] alg_of(input logic [4:0] m);
    return m[3] ? 2'd2 : (m[1] ? 2'd1 : 2'd0);
  endfunction

  function automatic logic [5:0] abits_of(input logic [4:0] m);
    return m[4] ? 6'd32 : 6'd24;
  endfunction

  function automatic logic [5:0] dummy_of(input logic [4:0] m, input logic fast,
                                          input logic [5:0] std_d, input logic [5:0] quad_d);
    if (dlg_of(m) == 2'd0 && !fast) return 6'd0;
    if (alg_of(m) == 2'd2)          return quad_d;
    return std_d;
  endfunction

  function automatic logic [5:0] seg_clocks(input seg_e s, input logic wr, input logic [4:0] m,
                                            input logic fast, input logic [5:0] std_d,
                                            input logic [5:0] quad_d);
    case (s)
      SEG_OPC: return 6'd8;
      SEG_ADR: return wr ? abits_of(m) : (abits_of(m) >> alg_of(m));
      SEG_DMY: return wr ? 6'd0 : dummy_of(m, fast, std_d, quad_d);
      default: return wr ? 6'd8 : (6'd8 >> dlg_of(m));
    endcase
  endfunction

  function automatic logic [1:0] seg_lg(input seg_e s, input logic wr, input logic [4:0] m);
    case (s)
      SEG_ADR: return wr ? 2'd0 : alg_of(m);
      SEG_DAT: return wr ? 2'd0 : dlg_of(m);
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] lg);
    case (lg)
      2'd0:    return 4'h1;
      2'd1:    return 4'h3;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [7:0] op_for(input logic wr, input logic mn, input logic [4:0] m,
                                        input logic [7:0] op_a, input logic [7:0] op_q);
    if (wr) return mn ? OP_PROG : OP_WREN;
    return m[2] ? op_q : op_a;
  endfunction

endpackage

// File: rtl/spi_pio_regs.sv
module spi_pio_regs
  import spi_pio_pkg::*;
#(
  parameter int ADDR_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [3:0]                reg_addr,
  input  logic [7:0]                reg_wdata,
  output logic [7:0]                reg_rdata,
  input  logic                      done,
  input  logic [7:0]                rx_byte,
  output logic [4:0]                mode,
  output logic                      fast,
  output logic [7:0]                op_a,
  output logic [7:0]                op_q,
  output logic [7:0]                wdata,
  output logic [ADDR_BYTES*8-1:0]   addr,
  output logic [7:0]                rd_q,
  output logic                      busy,
  output logic                      start,
  output logic                      start_wr
);
  localparam int AW = ADDR_BYTES * 8;

  logic [7:0] cmd_q;

  assign busy     = (cmd_q != 8'h00);
  assign start_wr = (reg_wdata == CMD_WR);
  assign start    = reg_we && !busy && (reg_addr == RG_CMD) &&
                    ((reg_wdata == CMD_RD) || (reg_wdata == CMD_WR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0; rd_q <= '0; wdata <= '0; mode <= '0; fast <= 1'b0;
      op_a  <= '0; op_q <= '0; addr  <= '0;
    end else if (done) begin
      if (cmd_q == CMD_RD) rd_q <= rx_byte;
      cmd_q <= '0;
      addr  <= addr + AW'(1);
    end else if (reg_we && !busy) begin
      if (start) cmd_q <= reg_wdata;
      case (reg_addr)
        RG_WDATA: wdata <= reg_wdata;
        RG_MODE:  mode  <= reg_wdata[4:0];
        RG_FAST:  fast  <= reg_wdata[0];
        RG_OPA:   op_a  <= reg_wdata;
        RG_OPQ:   op_q  <= reg_wdata;
        default: ;
      endcase
      for (int i = 0; i < ADDR_BYTES; i++)
        if (reg_addr == addr_off(i)) addr[8*i +: 8] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      RG_CMD:   reg_rdata = cmd_q;
      RG_RDATA: reg_rdata = rd_q;
      RG_WDATA: reg_rdata = wdata;
      RG_MODE:  reg_rdata = {3'b000, mode};
      RG_FAST:  reg_rdata = {7'b0, fast};
      RG_OPA:   reg_rdata = op_a;
      RG_OPQ:   reg_rdata = op_q;
      default: ;
    endcase
    for (int i = 0; i < ADDR_BYTES; i++)
      if (reg_addr == addr_off(i)) reg_rdata = addr[8*i +: 8];
  end

endmodule

// File: rtl/spi_pio_shift.sv
module spi_pio_shift #(
  parameter int TX_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld,
  input  logic [TX_W-1:0] ld_val,
  input  logic            shift_en,
  input  logic            sample_en,
  input  logic [1:0]      lane_lg,
  input  logic [3:0]      oe,
  input  logic [3:0]      io_in,
  output logic [3:0]      io_out,
  output logic [7:0]      rx_byte
);
  logic [TX_W-1:0] tx;
  logic [3:0]      raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx <= '0; rx_byte <= '0;
    end else begin
      if (ld)            tx <= ld_val;
      else if (shift_en) tx <= tx << (1 << lane_lg);
      if (sample_en) begin
        case (lane_lg)
          2'd0:    rx_byte <= {rx_byte[6:0], io_in[1]};
          2'd1:    rx_byte <= {rx_byte[5:0], io_in[1:0]};
          default: rx_byte <= {rx_byte[3:0], io_in};
        endcase
      end
    end
  end

  always_comb begin
    case (lane_lg)
      2'd0:    raw = {3'b000, tx[TX_W-1]};
      2'd1:    raw = {2'b00, tx[TX_W-1 -: 2]};
      default: raw = tx[TX_W-1 -: 4];
    endcase
  end

  assign io_out = raw & oe;

endmodule

// File: rtl/spi_pio_seq.sv
module spi_pio_seq
  import spi_pio_pkg::*;
#(
  parameter int GAP_CYC    = 2,
  parameter int DUMMY_STD  = 8,
  parameter int DUMMY_QUAD = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_wr,
  input  logic [4:0]  mode,
  input  logic        fast,
  input  logic [7:0]  op_a,
  input  logic [7:0]  op_q,
  input  logic [7:0]  wdata,
  input  logic [31:0] addr,
  output logic        sck,
  output logic        cs_n,
  output logic [3:0]  io_oe,
  output logic        done,
  output logic        ld,
  output logic [31:0] ld_val,
  output logic        shift_en,
  output logic        sample_en,
  output logic [1:0]  lane_lg
);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [5:0] D_STD  = 6'(DUMMY_STD);
  localparam logic [5:0] D_QUAD = 6'(DUMMY_QUAD);

  st_e            st;
  seg_e           seg, nxt;
  logic           ph, is_wr, main, nxt_ok;
  logic [5:0]     cnt, nxt_clk, dmy_clk;
  logic [GW-1:0]  gap;
  logic [31:0]    nxt_tx;

  assign dmy_clk = seg_clocks(SEG_DMY, is_wr, mode, fast, D_STD, D_QUAD);
  assign nxt_clk = seg_clocks(nxt, is_wr, mode, fast, D_STD, D_QUAD);

  // next segment of the current frame
  always_comb begin
    nxt = SEG_OPC; nxt_ok = 1'b0;
    if (main) begin
      case (seg)
        SEG_OPC: begin nxt = SEG_ADR; nxt_ok = 1'b1; end
        SEG_ADR: begin nxt = (dmy_clk != 6'd0) ? SEG_DMY : SEG_DAT; nxt_ok = 1'b1; end
        SEG_DMY: begin nxt = SEG_DAT; nxt_ok = 1'b1; end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (nxt)
      SEG_ADR: nxt_tx = mode[4] ? addr : {addr[23:0], 8'h00};
      SEG_DAT: nxt_tx = {wdata, 24'h0};
      default: nxt_tx = 32'h0;
    endcase
  end

  always_comb begin
    ld = 1'b0; ld_val = 32'h0;
    if (st == ST_IDLE && start) begin
      ld = 1'b1; ld_val = {op_for(start_wr, !start_wr, mode, op_a, op_q), 24'h0};
    end else if (st == ST_GAP && gap <= GW'(1)) begin
      ld = 1'b1; ld_val = {OP_PROG, 24'h0};
    end else if (st == ST_RUN && ph && cnt == 6'd1 && nxt_ok) begin
      ld = 1'b1; ld_val = nxt_tx;
    end
  end

  assign shift_en  = (st == ST_RUN) && ph && (cnt > 6'd1);
  assign sample_en = (st == ST_RUN) && !ph && (seg == SEG_DAT) && !is_wr;
  assign lane_lg   = seg_lg(seg, is_wr, mode);
  assign io_oe     = ((st == ST_RUN) &&
                      (seg == SEG_OPC || seg == SEG_ADR || (seg == SEG_DAT && is_wr)))
                     ? lane_mask(lane_lg) : 4'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; seg <= SEG_OPC; ph <= 1'b0; is_wr <= 1'b0; main <= 1'b0;
      cnt <= '0; gap <= '0; sck <= 1'b0; cs_n <= 1'b1; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          is_wr <= start_wr; main <= !start_wr;
          st <= ST_RUN; cs_n <= 1'b0; ph <= 1'b0; seg <= SEG_OPC; cnt <= 6'd8;
        end
        ST_RUN: begin
          if (!ph) begin
            ph <= 1'b1; sck <= 1'b1;
          end else begin
            ph <= 1'b0; sck <= 1'b0;
            if (cnt > 6'd1) cnt <= cnt - 6'd1;
            else if (nxt_ok) begin
              seg <= nxt; cnt <= nxt_clk;
            end else begin
              cs_n <= 1'b1;
              if (main) begin st <= ST_IDLE; done <= 1'b1; end
              else begin st <= ST_GAP; gap <= GW'(GAP_CYC); end
            end
          end
        end
        ST_GAP: begin
          if (gap <= GW'(1)) begin
            main <= 1'b1; st <= ST_RUN; cs_n <= 1'b0; ph <= 1'b0;
            seg <= SEG_OPC; cnt <= 6'd8;
          end else gap <= gap - GW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_pio_byte_engine.sv
module spi_pio_byte_engine
  import spi_pio_pkg::*;
#(
  parameter int GAP_CYC    = 2,
  parameter int DUMMY_STD  = 8,
  parameter int DUMMY_QUAD = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic [3:0] spi_io_out,
  output logic [3:0] spi_io_oe,
  input  logic [3:0] spi_io_in
);
  localparam int ADDR_BYTES = 4;
  localparam int AW = ADDR_BYTES * 8;

  // named internal events, used by the bound checker
  logic          start_evt, start_wr, done_evt, busy;
  logic [AW-1:0] cur_addr;
  logic [7:0]    rd_q, rx_byte, op_a, op_q, wdata;
  logic [4:0]    mode;
  logic          fast;
  logic          ld, shift_en, sample_en;
  logic [31:0]   ld_val;
  logic [1:0]    lane_lg;

  spi_pio_regs #(.ADDR_BYTES(ADDR_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done_evt), .rx_byte(rx_byte),
    .mode(mode), .fast(fast), .op_a(op_a), .op_q(op_q), .wdata(wdata),
    .addr(cur_addr), .rd_q(rd_q), .busy(busy), .start(start_evt), .start_wr(start_wr)
  );

  spi_pio_seq #(.GAP_CYC(GAP_CYC), .DUMMY_STD(DUMMY_STD), .DUMMY_QUAD(DUMMY_QUAD)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .start_wr(start_wr), .mode(mode),
    .fast(fast), .op_a(op_a), .op_q(op_q), .wdata(wdata), .addr(cur_addr),
    .sck(spi_sck), .cs_n(spi_cs_n), .io_oe(spi_io_oe), .done(done_evt),
    .ld(ld), .ld_val(ld_val), .shift_en(shift_en), .sample_en(sample_en), .lane_lg(lane_lg)
  );

  spi_pio_shift #(.TX_W(32)) u_shift (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_val), .shift_en(shift_en),
    .sample_en(sample_en), .lane_lg(lane_lg), .oe(spi_io_oe), .io_in(spi_io_in),
    .io_out(spi_io_out), .rx_byte(rx_byte)
  );

endmodule

// File: rtl/spi_pio_byte_engine_chk.sv
module spi_pio_byte_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        sck,
  input logic [3:0]  io_oe,
  input logic        start_evt,
  input logic        done_evt,
  input logic        busy,
  input logic [31:0] addr,
  input logic [7:0]  rd_q
);
  a_r11_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  a_r11_oe_idle_off:  assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> io_oe == 4'h0);
  a_r11_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n) done_evt |-> cs_n);
  a_r7_oe_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'h0) || (io_oe == 4'h1) || (io_oe == 4'h3) || (io_oe == 4'hF));
  a_r3_busy_set:   assert property (@(posedge clk) disable iff (!rst_n) start_evt |=> busy);
  a_r3_busy_clear: assert property (@(posedge clk) disable iff (!rst_n) done_evt |=> !busy);
  a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n) !done_evt |=> $stable(rd_q));
  a_r9_addr_step:  assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> addr == $past(addr) + 32'd1);
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_evt) |=> $stable(addr));
endmodule

bind spi_pio_byte_engine spi_pio_byte_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .io_oe(spi_io_oe),
  .start_evt(start_evt), .done_evt(done_evt), .busy(busy), .addr(cur_addr), .rd_q(rd_q)
);

// File: tb/spi_pio_byte_engine_tb_top.sv
module spi_pio_byte_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       spi_sck, spi_cs_n;
  logic [3:0] spi_io_out, spi_io_oe;
  logic [3:0] spi_io_in = 4'h0;

  always #5 clk = ~clk;

  spi_pio_byte_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out),
    .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic        m_wr = 1'b0;
  int          m_alg = 0, m_dlg = 0, m_abits = 24, m_dstart = 1000;
  int          fcnt = 0, oe_bad = 0, sck_bad = 0, frames = 0, l_cnt = 0, p_cnt = 0, l_gap = 0;
  logic [7:0]  c_op = 0, c_wd = 0, l_op = 0, p_op = 0, l_wd = 0;
  logic [31:0] c_ad = 0, l_ad = 0;
  time         t_hi = 0, t_sck = 0;

  function automatic logic [7:0] mem_of(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'hA5;
  endfunction

  always @(negedge spi_cs_n) begin
    l_gap = int'(($time - t_hi) / 10);
    fcnt = 0; c_op = 0; c_ad = 0; c_wd = 0;
  end

  always @(posedge spi_cs_n) begin
    if (rst_n) begin
      frames++;
      p_op = l_op; p_cnt = l_cnt;
      l_op = c_op; l_ad = c_ad; l_wd = c_wd; l_cnt = fcnt;
      t_hi = $time;
    end
  end

  always @(posedge spi_sck) begin
    int aclk;
    aclk = m_abits >> m_alg;
    if (spi_cs_n) sck_bad++;
    if (fcnt > 0 && ($time - t_sck) != 20) sck_bad++;
    t_sck = $time;
    if (fcnt < 8) c_op = {c_op[6:0], spi_io_out[0]};
    else if (fcnt < 8 + aclk) begin
      case (m_alg)
        0: c_ad = {c_ad[30:0], spi_io_out[0]};
        1: c_ad = {c_ad[29:0], spi_io_out[1:0]};
        default: c_ad = {c_ad[27:0], spi_io_out};
      endcase
    end else if (m_wr && fcnt < 16 + aclk) c_wd = {c_wd[6:0], spi_io_out[0]};
    else if (!m_wr && spi_io_oe != 4'h0) oe_bad++;
    fcnt++;
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n && !m_wr && fcnt >= m_dstart) begin
      int j;
      logic [7:0] b;
      j = fcnt - m_dstart;
      b = mem_of(c_ad);
      if (m_dlg == 0 && j < 8)      spi_io_in = {2'b11, b[7-j], ~b[7-j]};
      else if (m_dlg == 1 && j < 4) spi_io_in = {~b[7-2*j], ~b[6-2*j], b[7-2*j], b[6-2*j]};
      else if (m_dlg == 2 && j < 2) spi_io_in = (j == 0) ? b[7:4] : b[3:0];
    end
  end

  // ---------------- register access ----------------
  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd_addr(output logic [31:0] a);
    logic [7:0] b0, b1, b2, b3;
    rd_reg(4'h8, b0); rd_reg(4'h9, b1); rd_reg(4'hA, b2); rd_reg(4'hD, b3);
    a = {b3, b2, b1, b0};
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] c;
    bit idle;
    idle = 0;
    for (int k = 0; k < 1000 && !idle; k++) begin
      rd_reg(4'h0, c);
      if (c == 8'h00) idle = 1;
    end
    check(idle, tag, {24'h0, c}, 32'h0);
  endtask

  task automatic set_cfg(input logic [4:0] m, input logic f, input logic [31:0] a,
                         input logic [7:0] oa, input logic [7:0] oq);
    wr_reg(4'h3, {3'b000, m}); wr_reg(4'h4, {7'b0, f});
    wr_reg(4'h5, oa); wr_reg(4'h6, oq);
    wr_reg(4'h8, a[7:0]); wr_reg(4'h9, a[15:8]); wr_reg(4'hA, a[23:16]); wr_reg(4'hD, a[31:24]);
  endtask

  // bench's own restatement of the mode rules
  function automatic int exp_dummy(input logic [4:0] m, input logic f);
    if (!m[2] && !m[0] && !f) return 0;
    if (m[3]) return 6;
    return 8;
  endfunction

  function automatic logic [31:0] sent_addr(input logic [4:0] m, input logic [31:0] a);
    return m[4] ? a : {8'h00, a[23:0]};
  endfunction

  logic [7:0]  opa_cur = 8'h0B, opq_cur = 8'h6B;

  // issue one read at address a (already loaded), mode m, fast f
  task automatic do_read(input logic [4:0] m, input logic f, input logic [31:0] a);
    logic [7:0]  d, c;
    logic [31:0] na;
    int          f0, ab;
    m_wr = 1'b0;
    m_alg = m[3] ? 2 : (m[1] ? 1 : 0);
    m_dlg = m[2] ? 2 : (m[0] ? 1 : 0);
    m_abits = m[4] ? 32 : 24;
    ab = m_abits >> m_alg;
    m_dstart = 8 + ab + exp_dummy(m, f);
    f0 = frames;
    wr_reg(4'h0, 8'h81);
    rd_reg(4'h0, c);
    check(c == 8'h81, "R3 busy reads 0x81", {24'h0, c}, 32'h81);
    wait_idle("R3 command completes");
    rd_reg(4'h1, d);
    check(d == mem_of(sent_addr(m, a)), (m_dlg != 0) ? "R7 lane data" : "R3 read data",
          {24'h0, d}, {24'h0, mem_of(sent_addr(m, a))});
    check(frames == f0 + 1, "R3 one frame", frames - f0, 1);
    check(l_op == (m[2] ? opq_cur : opa_cur), "R4 opcode", {24'h0, l_op},
          {24'h0, (m[2] ? opq_cur : opa_cur)});
    check(l_ad == sent_addr(m, a), "R5 address bits", l_ad, sent_addr(m, a));
    check(l_cnt == m_dstart + (8 >> m_dlg), "R6 clock count", l_cnt, m_dstart + (8 >> m_dlg));
    rd_addr(na);
    check(na == a + 1, "R9 address increment", na, a + 1);
  endtask

  task automatic do_write(input logic [4:0] m, input logic [31:0] a, input logic [7:0] wd);
    logic [31:0] na;
    int          f0;
    m_wr = 1'b1; m_alg = 0; m_dlg = 0; m_abits = m[4] ? 32 : 24; m_dstart = 1000;
    wr_reg(4'h2, wd);
    f0 = frames;
    wr_reg(4'h0, 8'h90);
    wait_idle("R8 command completes");
    check(frames == f0 + 2, "R8 two frames", frames - f0, 2);
    check(p_op == 8'h06 && p_cnt == 8, "R8 write-enable frame", {p_op, 24'(p_cnt)}, {8'h06, 24'd8});
    check(l_op == 8'h02, "R8 program opcode", {24'h0, l_op}, 32'h02);
    check(l_ad == sent_addr(m, a), "R8 program address", l_ad, sent_addr(m, a));
    check(l_wd == wd, "R8 program data", {24'h0, l_wd}, {24'h0, wd});
    check(l_cnt == 16 + m_abits, "R8 program clocks", l_cnt, 16 + m_abits);
    check(l_gap >= 2, "R8 chip-select gap", l_gap, 2);
    rd_addr(na);
    check(na == a + 1, "R9 address increment after write", na, a + 1);
  endtask

  // watchdog
  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [31:0] a, na;
    int          f0;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    frames = 0;
    @(negedge clk);
    // R1 reset state
    check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && spi_io_oe == 4'h0, "R1 pins idle",
          {spi_cs_n, spi_sck, spi_io_oe}, 6'b100000);
    rd_reg(4'h0, d); check(d == 8'h00, "R1 command reg", {24'h0, d}, 0);
    rd_reg(4'h1, d); check(d == 8'h00, "R1 read-data reg", {24'h0, d}, 0);
    rd_addr(a);      check(a == 32'h0, "R1 address regs", a, 0);

    // R2 address register readback
    set_cfg(5'h00, 1'b0, 32'hC3_5A_21_F0, opa_cur, opq_cur);
    rd_addr(a); check(a == 32'hC35A21F0, "R2 address readback", a, 32'hC35A21F0);

    // directed reads across the lane modes
    do_read(5'h00, 1'b0, 32'hC35A21F0);                 // plain single, no dummy
    set_cfg(5'h00, 1'b1, 32'h0012_3456, opa_cur, opq_cur);
    do_read(5'h00, 1'b1, 32'h0012_3456);                // fast single
    set_cfg(5'h01, 1'b0, 32'h00AB_CDEF, opa_cur, opq_cur);
    do_read(5'h01, 1'b0, 32'h00AB_CDEF);                // dual data
    set_cfg(5'h03, 1'b0, 32'h0001_0203, opa_cur, opq_cur);
    do_read(5'h03, 1'b0, 32'h0001_0203);                // dual addr + data
    set_cfg(5'h04, 1'b0, 32'h0077_8899, opa_cur, opq_cur);
    do_read(5'h04, 1'b0, 32'h0077_8899);                // quad data, single addr
    set_cfg(5'h1C, 1'b0, 32'h89AB_CDEF, opa_cur, opq_cur);
    do_read(5'h1C, 1'b0, 32'h89AB_CDEF);                // quad addr + data, 4-byte (R5)
    set_cfg(5'h1F, 1'b1, 32'hFFFF_FFFF, opa_cur, opq_cur);
    do_read(5'h1F, 1'b1, 32'hFFFF_FFFF);                // all bits: quad wins, address wraps
    check(1'b1, "R4 quad priority exercised", 0, 0);

    // R9 consecutive reads without reload
    set_cfg(5'h01, 1'b0, 32'h0000_00FE, opa_cur, opq_cur);
    do_read(5'h01, 1'b0, 32'h0000_00FE);
    do_read(5'h01, 1'b0, 32'h0000_00FF);
    do_read(5'h01, 1'b0, 32'h0000_0100);

    // writes, 3- and 4-byte
    set_cfg(5'h00, 1'b0, 32'h0055_AA01, opa_cur, opq_cur);
    do_write(5'h00, 32'h0055_AA01, 8'h3C);
    do_write(5'h00, 32'h0055_AA02, 8'hC7);
    set_cfg(5'h1F, 1'b0, 32'hDEAD_BEEF, opa_cur, opq_cur);
    do_write(5'h1F, 32'hDEAD_BEEF, 8'h81);

    // R10 writes ignored while busy
    set_cfg(5'h00, 1'b1, 32'h0000_4000, opa_cur, opq_cur);
    m_wr = 1'b0; m_alg = 0; m_dlg = 0; m_abits = 24; m_dstart = 8 + 24 + 8;
    f0 = frames;
    wr_reg(4'h0, 8'h81);
    wr_reg(4'h8, 8'h3C);
    wr_reg(4'h3, 8'h1F);
    wr_reg(4'h0, 8'h90);
    wait_idle("R10 command completes");
    rd_addr(na); check(na == 32'h0000_4001, "R10 address write dropped", na, 32'h4001);
    rd_reg(4'h3, d); check(d == 8'h00, "R10 mode write dropped", {24'h0, d}, 0);
    check(frames == f0 + 1, "R10 second command dropped", frames - f0, 1);
    rd_reg(4'h1, d); check(d == mem_of(32'h4000), "R10 read data", {24'h0, d}, {24'h0, mem_of(32'h4000)});

    // R10 unknown command value
    f0 = frames;
    wr_reg(4'h0, 8'h55);
    rd_reg(4'h0, d); check(d == 8'h00, "R10 unknown command ignored", {24'h0, d}, 0);
    repeat (60) @(negedge clk);
    check(frames == f0 && spi_cs_n, "R10 no frame for unknown command", frames - f0, 0);

    // constrained random mix
    for (int it = 0; it < 30; it++) begin
      logic [4:0]  m;
      logic        f;
      logic [31:0] ra;
      m  = 5'($urandom_range(0, 31));
      f  = 1'($urandom_range(0, 1));
      ra = $urandom;
      opa_cur = 8'($urandom); opq_cur = 8'($urandom);
      set_cfg(m, f, ra, opa_cur, opq_cur);
      if ($urandom_range(0, 3) == 0) do_write(m, ra, 8'($urandom));
      else                           do_read(m, f, ra);
    end

    check(oe_bad == 0, "R11 lanes released in dummy and read data", oe_bad, 0);
    check(sck_bad == 0, "R11 SCK period and idle level", sck_bad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule